// File: doc/BRIEF.md
# I2C Byte Shifter with Acknowledge Handling

This block moves one I2C frame of eight data bits and a ninth acknowledge bit. A separate clock block produces the bus clock and passes it in as two single-cycle strobes, one for the SCL rising edge and one for the falling edge. A one-cycle `start` pulse, given while SCL is low, begins a frame. In transmit mode the block drives the loaded byte MSB first. It does this through an open-drain low enable, so a `1` bit releases the line. It releases the line for the ninth slot and samples the acknowledge there. In receive mode it releases the line for the data bits. For the ninth slot it can drive a programmed acknowledge value.

The block captures the bus level on every SCL rising edge and packs the bits into a 9-bit receive word in one of two layouts. An alternate-phase option returns the final word in the plain layout. The line can be released at all times with a disable input. Each change of the drive value can be held back by a programmable number of baud-source ticks. After the ninth rising edge the block gives a frame-done pulse. In the plain layout it also gives either an ACK or a NACK pulse. The block releases the line and goes idle on the SCL falling edge that follows the ninth bit.

Top module: `i2cByteShifter`

## Requirements
- R1: In transmit mode (`txMode`=1), during data slot k (k=0..7) `sdaDriveLow` equals the inverse of `txByte[7-k]`. During the ninth slot the line is released (`sdaDriveLow`=0). Slot 0 begins on the cycle after `start` and each later slot begins on the cycle after an `sclFall` strobe.
- R2: When `delaySel`=0, a new drive value appears on `sdaDriveLow` on the cycle after the slot begins. When `delaySel`=n (1..7), the change appears only after n+1 `baudTick` strobes, and `sdaDriveLow` changes only on a cycle that follows a `baudTick`.
- R3: While `sdaDisable`=1, `sdaDriveLow` is 0 whatever the frame state.
- R4: With `layoutSel`=0, the word at frame end is `rxWord[7:0]` = the eight sampled bits, first-sampled in bit 7, and `rxWord[8]` = the bus level at the ninth rising edge.
- R5: With `layoutSel`=1 and `altPhase`=0, the first seven sampled bits go to `rxWord[6:0]`, the eighth goes to `rxWord[8]`, and the ninth-slot level goes to `rxWord[7]`. This arrangement, with bit 7 reading 0, is already present after the eighth rising edge.
- R6: With `layoutSel`=1 and `altPhase`=1, the word after the ninth rising edge uses the R4 arrangement.
- R7: In receive mode, when `startStopEn`=0 and `ackOutEn`=1, the line is driven low during the ninth slot if `ackData`=0 and released if `ackData`=1. In every other case the ninth slot is released in receive mode, and all receive data slots are released.
- R8: With `layoutSel`=0, the frame end raises `ackPulse` if the bus was low at the ninth rising edge, or `nackPulse` if it was high. The two never rise together. With `layoutSel`=1 neither pulse rises.
- R9: `frameDone` is a one-cycle pulse on the cycle after the ninth rising edge, and it coincides with the final `rxWord` and the ACK/NACK pulse. `busy` drops on the cycle after the following `sclFall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (accepted when idle, SCL low) |
| txMode | input | 1 | 1 = transmit byte, 0 = receive byte |
| txByte | input | 8 | Byte to transmit, loaded on `start` |
| sclRise | input | 1 | SCL rising-edge strobe from the clock block |
| sclFall | input | 1 | SCL falling-edge strobe from the clock block |
| baudTick | input | 1 | Baud count-source tick used for the output delay |
| delaySel | input | 3 | 0 = no delay, n = delay of n+1 ticks |
| sdaDisable | input | 1 | Force SDA released |
| layoutSel | input | 1 | Receive word layout select |
| altPhase | input | 1 | Alternate clock phase: final word in plain layout |
| ackOutEn | input | 1 | Drive programmed ACK bit in receive mode |
| startStopEn | input | 1 | Start/stop output enabled (blocks ACK drive) |
| ackData | input | 1 | ACK bit value to drive |
| sdaIn | input | 1 | Sampled SDA bus level |
| sdaDriveLow | output | 1 | Open-drain pull-low enable for SDA |
| busy | output | 1 | Frame in progress |
| frameDone | output | 1 | End-of-frame pulse |
| rxWord | output | 9 | Received word |
| ackPulse | output | 1 | Acknowledge seen |
| nackPulse | output | 1 | No-acknowledge seen |

## Verification
The assertions assume that the configuration inputs (`delaySel`, `layoutSel`, `altPhase`, the ACK controls) change only between frames. They also assume that the edge strobes alternate and are spaced further apart than the longest output delay, so that no drive change is still pending when the next slot begins. The bench sets all configuration while the block is idle. It places each strobe 24 cycles after the previous one, with a tick every second cycle, which gives 12 ticks against a maximum delay of 8. It models the bus as a wired AND of the block's drive and a modelled slave's drive, so `sdaIn` always reflects a legal open-drain level.

// File: rtl/i2cShiftPkg.sv
package i2cShiftPkg;
  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;     // frame accepted, present slot 0
    logic sample;   // SCL rising edge inside a frame
    logic advance;  // SCL falling edge, next slot
    logic finish;   // rising edge of the ninth slot
    logic drop;     // falling edge after the ninth slot
  } shiftStrobes_t;
endpackage

// File: rtl/i2cShiftCtrl.sv
module i2cShiftCtrl
  import i2cShiftPkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sclRise,
  input  logic              sclFall,
  output shiftStrobes_t     strobes,
  output logic [IDX_W-1:0]  bitIdx,
  output logic              busy
);
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_HOLD} state_t;
  state_t state;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W);

  always_comb begin
    strobes = '0;
    unique case (state)
      ST_IDLE:  strobes.load = start;
      ST_SHIFT: begin
        if (sclRise) begin
          strobes.sample = 1'b1;
          strobes.finish = (bitIdx == LAST_IDX);
        end else if (sclFall && bitIdx != LAST_IDX) begin
          strobes.advance = 1'b1;
        end
      end
      ST_HOLD:  strobes.drop = sclFall;
      default:  strobes = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
    end else begin
      if (strobes.load) begin
        state  <= ST_SHIFT;
        bitIdx <= '0;
      end else if (strobes.finish) begin
        state  <= ST_HOLD;
      end else if (strobes.advance) begin
        bitIdx <= bitIdx + 1'b1;
      end else if (strobes.drop) begin
        state  <= ST_IDLE;
        bitIdx <= '0;
      end
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/i2cShiftDp.sv
module i2cShiftDp
  import i2cShiftPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DLY_W  = 3,
  localparam int IDX_W = $clog2(DATA_W + 1),
  localparam int CNT_W = DLY_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  shiftStrobes_t     strobes,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              txMode,
  input  logic [DATA_W-1:0] txByte,
  input  logic [DLY_W-1:0]  delaySel,
  input  logic              sdaDisable,
  input  logic              layoutSel,
  input  logic              altPhase,
  input  logic              ackOutEn,
  input  logic              startStopEn,
  input  logic              ackData,
  input  logic              sdaIn,
  input  logic              baudTick,
  output logic              sdaDriveLow,
  output logic              frameDone,
  output logic [DATA_W:0]   rxWord,
  output logic              ackPulse,
  output logic              nackPulse
);
  localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(DATA_W - 1);

  logic              txModeQ;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] dataNext;
  logic              tgtLow, tgtNext, tgtWr;
  logic              outDly;
  logic [CNT_W-1:0]  dlyCnt, dlyLen;

  // target drive level for the slot being entered
  always_comb begin
    tgtWr   = 1'b0;
    tgtNext = tgtLow;
    if (strobes.load) begin
      tgtWr   = 1'b1;
      tgtNext = txMode & ~txByte[DATA_W-1];
    end else if (strobes.advance) begin
      tgtWr = 1'b1;
      if (bitIdx == LAST_DATA)
        tgtNext = ~txModeQ & ~startStopEn & ackOutEn & ~ackData;
      else
        tgtNext = txModeQ & ~txShift[DATA_W-2];
    end else if (strobes.drop) begin
      tgtWr   = 1'b1;
      tgtNext = 1'b0;
    end
  end

  assign dataNext = {rxShift[DATA_W-2:0], sdaIn};
  assign dlyLen   = (delaySel == '0) ? '0 : CNT_W'(delaySel) + CNT_W'(1);

  // transmit side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txModeQ <= 1'b0;
      txShift <= '0;
    end else if (strobes.load) begin
      txModeQ <= txMode;
      txShift <= txByte;
    end else if (strobes.advance) begin
      txShift <= {txShift[DATA_W-2:0], 1'b0};
    end
  end

  // output delay line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgtLow <= 1'b0;
      outDly <= 1'b0;
      dlyCnt <= '0;
    end else if (tgtWr) begin
      tgtLow <= tgtNext;
      dlyCnt <= dlyLen;
    end else if (dlyCnt != '0) begin
      if (baudTick) begin
        dlyCnt <= dlyCnt - 1'b1;
        if (dlyCnt == CNT_W'(1)) outDly <= tgtLow;
      end
    end else begin
      outDly <= tgtLow;
    end
  end

  assign sdaDriveLow = ~sdaDisable & ((delaySel == '0) ? tgtLow : outDly);

  // receive side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShift   <= '0;
      rxWord    <= '0;
      frameDone <= 1'b0;
      ackPulse  <= 1'b0;
      nackPulse <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      ackPulse  <= 1'b0;
      nackPulse <= 1'b0;
      if (strobes.sample && !strobes.finish) begin
        rxShift <= dataNext;
        if (bitIdx == LAST_DATA)
          rxWord <= layoutSel ? {dataNext[0], 1'b0, dataNext[DATA_W-1:1]}
                              : {1'b0, dataNext};
      end
      if (strobes.finish) begin
        rxWord    <= (layoutSel && !altPhase)
                     ? {rxShift[0], sdaIn, rxShift[DATA_W-1:1]}
                     : {sdaIn, rxShift};
        frameDone <= 1'b1;
        ackPulse  <= ~layoutSel & ~sdaIn;
        nackPulse <= ~layoutSel &  sdaIn;
      end
    end
  end
endmodule

// File: rtl/i2cByteShifter.sv
module i2cByteShifter
  import i2cShiftPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DLY_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              txMode,
  input  logic [DATA_W-1:0] txByte,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              baudTick,
  input  logic [DLY_W-1:0]  delaySel,
  input  logic              sdaDisable,
  input  logic              layoutSel,
  input  logic              altPhase,
  input  logic              ackOutEn,
  input  logic              startStopEn,
  input  logic              ackData,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  output logic              busy,
  output logic              frameDone,
  output logic [DATA_W:0]   rxWord,
  output logic              ackPulse,
  output logic              nackPulse
);
  localparam int IDX_W = $clog2(DATA_W + 1);

  shiftStrobes_t    strobes;
  logic [IDX_W-1:0] bitIdx;

  i2cShiftCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .sclRise(sclRise), .sclFall(sclFall),
    .strobes(strobes), .bitIdx(bitIdx), .busy(busy)
  );

  i2cShiftDp #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .bitIdx(bitIdx),
    .txMode(txMode), .txByte(txByte), .delaySel(delaySel),
    .sdaDisable(sdaDisable), .layoutSel(layoutSel), .altPhase(altPhase),
    .ackOutEn(ackOutEn), .startStopEn(startStopEn), .ackData(ackData),
    .sdaIn(sdaIn), .baudTick(baudTick), .sdaDriveLow(sdaDriveLow),
    .frameDone(frameDone), .rxWord(rxWord),
    .ackPulse(ackPulse), .nackPulse(nackPulse)
  );
endmodule

// File: rtl/i2cShiftChecker.sv
module i2cShiftChecker #(
  parameter int DLY_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sdaDisable,
  input logic             sdaDriveLow,
  input logic             sdaIn,
  input logic             baudTick,
  input logic [DLY_W-1:0] delaySel,
  input logic             frameDone,
  input logic             ackPulse,
  input logic             nackPulse
);
  // R3
  sda_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdaDisable |-> !sdaDriveLow);

  // R2
  delay_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (delaySel != '0 && $stable(delaySel) && !sdaDisable && !$past(sdaDisable)
     && !$stable(sdaDriveLow)) |-> $past(baudTick));

  // R8
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ackPulse && nackPulse));

  // R8
  ack_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ackPulse |-> !$past(sdaIn));

  // R8
  nack_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nackPulse |-> $past(sdaIn));

  // R9
  pulse_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ackPulse || nackPulse) |-> frameDone);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |=> !frameDone);
endmodule

bind i2cByteShifter i2cShiftChecker #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdaDisable(sdaDisable),
  .sdaDriveLow(sdaDriveLow), .sdaIn(sdaIn), .baudTick(baudTick),
  .delaySel(delaySel), .frameDone(frameDone),
  .ackPulse(ackPulse), .nackPulse(nackPulse)
);

// File: tb/i2cByteShifter_bench.sv
module i2cByteShifter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic start = 0, txMode = 0, sclRise = 0, sclFall = 0, baudTick = 0;
  logic [7:0] txByte = 0;
  logic [2:0] delaySel = 0;
  logic sdaDisable = 0, layoutSel = 0, altPhase = 0;
  logic ackOutEn = 0, startStopEn = 0, ackData = 0;
  logic slaveLow = 0;
  logic sdaIn;
  logic sdaDriveLow, busy, frameDone, ackPulse, nackPulse;
  logic [8:0] rxWord;

  assign sdaIn = ~sdaDriveLow & ~slaveLow;

  i2cByteShifter u_i2cByteShifter (
    .clk(clk), .rst_n(rst_n), .start(start), .txMode(txMode), .txByte(txByte),
    .sclRise(sclRise), .sclFall(sclFall), .baudTick(baudTick),
    .delaySel(delaySel), .sdaDisable(sdaDisable), .layoutSel(layoutSel),
    .altPhase(altPhase), .ackOutEn(ackOutEn), .startStopEn(startStopEn),
    .ackData(ackData), .sdaIn(sdaIn), .sdaDriveLow(sdaDriveLow), .busy(busy),
    .frameDone(frameDone), .rxWord(rxWord), .ackPulse(ackPulse),
    .nackPulse(nackPulse)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct packed { logic [8:0] word; logic ack; logic nack; } expItem_t;
  expItem_t expQ[$];

  task automatic check(input string req, input string what,
                       input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      baudTick = ~baudTick;
    end
  end

  // monitor: pop expected frame results as frames complete (R4 R5 R6 R8 R9)
  initial begin
    forever begin
      @(negedge clk);
      if (frameDone && rst_n) begin
        if (expQ.size() == 0) begin
          check("R9", "unexpected frameDone", 9'd1, 9'd0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check("R4_R5_R6", "rxWord at frameDone", rxWord, e.word);
          check("R8", "ackPulse", {8'd0, ackPulse}, {8'd0, e.ack});
          check("R8", "nackPulse", {8'd0, nackPulse}, {8'd0, e.nack});
        end
      end
    end
  end

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic runFrame(input logic tx, input logic [7:0] data,
                          input logic slaveAck, input logic lay,
                          input logic alt, input logic ackEn, input logic ssEn,
                          input logic ackD, input logic [2:0] dly,
                          input logic dis);
    logic ml [9];
    logic sl [9];
    logic bus [9];
    logic [8:0] w;
    expItem_t e;
    txMode = tx; txByte = data; layoutSel = lay; altPhase = alt;
    ackOutEn = ackEn; startStopEn = ssEn; ackData = ackD;
    delaySel = dly; sdaDisable = dis;
    for (int k = 0; k < 9; k++) begin
      if (k < 8) begin
        ml[k] = tx & ~data[7-k];
        sl[k] = ~tx & ~data[7-k];
      end else begin
        ml[k] = ~tx & ~ssEn & ackEn & ~ackD;
        sl[k] = tx & ~slaveAck;
      end
      if (dis) ml[k] = 1'b0;
      bus[k] = ~(ml[k] | sl[k]);
    end
    for (int k = 0; k < 8; k++) w[7-k] = bus[k];
    if (lay && !alt) e.word = {w[0], bus[8], w[7:1]};
    else             e.word = {bus[8], w[7:0]};
    e.ack  = ~lay & ~bus[8];
    e.nack = ~lay &  bus[8];
    expQ.push_back(e);

    @(negedge clk);
    pulse(start);
    for (int k = 0; k < 9; k++) begin
      slaveLow = sl[k];
      if (k == 0) begin
        @(negedge clk);
        check("R2", "early drive of slot 0", {8'd0, sdaDriveLow},
              {8'd0, (dly == 0) ? ml[0] : 1'b0});
        repeat (22) @(negedge clk);
      end else begin
        repeat (23) @(negedge clk);
      end
      if (dis)
        check("R3", "drive while disabled", {8'd0, sdaDriveLow}, 9'd0);
      else if (k == 8 && !tx)
        check("R7", "ack slot drive", {8'd0, sdaDriveLow}, {8'd0, ml[k]});
      else
        check(tx ? "R1" : "R7", "slot drive", {8'd0, sdaDriveLow}, {8'd0, ml[k]});
      pulse(sclRise);
      if (k == 7 && lay) begin
        @(negedge clk);
        check("R5", "word after eighth rise", rxWord, {w[0], 1'b0, w[7:1]});
        repeat (22) @(negedge clk);
      end else begin
        repeat (23) @(negedge clk);
      end
      if (k == 8) begin
        check("R9", "busy held until final fall", {8'd0, busy}, 9'd1);
        slaveLow = 1'b0;
      end
      pulse(sclFall);
    end
    check("R9", "busy after final fall", {8'd0, busy}, 9'd0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "reset busy", {8'd0, busy}, 9'd0);
    check("R9", "reset frameDone", {8'd0, frameDone}, 9'd0);
    check("R1", "reset drive", {8'd0, sdaDriveLow}, 9'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // transmit, acknowledged (R1, R4, R8)
    runFrame(1, 8'hA5, 0, 0, 0, 0, 0, 0, 3'd0, 0);
    // transmit, not acknowledged (R1, R8)
    runFrame(1, 8'h3C, 1, 0, 0, 0, 0, 0, 3'd0, 0);
    // transmit with output delay of 4 and 8 ticks (R2)
    runFrame(1, 8'h5E, 0, 0, 0, 0, 0, 0, 3'd3, 0);
    runFrame(1, 8'h01, 1, 0, 0, 0, 0, 0, 3'd7, 0);
    // disabled output (R3)
    runFrame(1, 8'h00, 0, 0, 0, 0, 0, 0, 3'd0, 1);
    // receive, driven ACK (R7, R4, R8)
    runFrame(0, 8'h5A, 0, 0, 0, 1, 0, 0, 3'd0, 0);
    // receive, ACK blocked by start/stop enable (R7)
    runFrame(0, 8'h96, 0, 0, 0, 1, 1, 0, 3'd0, 0);
    // receive, ACK output off (R7)
    runFrame(0, 8'hF0, 0, 0, 0, 0, 0, 0, 3'd2, 0);
    // receive, layout 1 (R5, R8 no pulses)
    runFrame(0, 8'hC3, 0, 1, 0, 1, 0, 1, 3'd0, 0);
    runFrame(0, 8'h6D, 0, 1, 0, 1, 0, 0, 3'd0, 0);
    // receive, layout 1 with alternate phase (R6)
    runFrame(0, 8'hB1, 0, 1, 1, 1, 0, 0, 3'd0, 0);
    check("R9", "all frames completed", 9'(expQ.size()), 9'd0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule